// File: doc/BRIEF.md
# Seconds Counter with Two Alarm Comparators

This peripheral keeps wall-clock time as a 32-bit count of whole seconds. The count advances by one on each pulse of a one-second tick input. Software reads and writes it through a small word-addressed register port. Two alarm comparators each hold a target seconds value and a three-bit interrupt configuration word.

When the count steps onto an alarm's target, that alarm's flag in a shared status register is set. The flag stays set until software writes a one to its bit. Each alarm drives its own interrupt line, which can be raised by the latched alarm flag, by a once-per-second periodic pulse, or by both, depending on its configuration word.

A host would typically do the following:
- load the time;
- program an alarm value and enable it;
- wait for the interrupt line;
- acknowledge through the status register.

A write of zero to the status register changes nothing, so it is harmless as a dummy access before any other write.

Top module: `rtcx_timer`

## Requirements
- R1: After a synchronous reset, the following are all zero: time, both alarm values, both configuration words, the status flags and the read data. Both interrupt lines are low.
- R2: Each tick pulse increments the seconds count by one, wrapping from 0xFFFFFFFF to 0. Without a tick or a load, the count holds.
- R3: A write to the time register at word offset 0xC loads the count. If a tick arrives in the same cycle, the load wins, and counting resumes from the loaded value on the next tick.
- R4: Status bit n is set on the tick that moves the count onto alarm n's value. Alarm 0 is at offset 0x10 and maps to status bit 0; alarm 1 is at 0x14 and maps to bit 1. Loading the count directly to the alarm value does not set the flag.
- R5: A status flag stays set whatever its enable, until a write to the status register (offset 0x0) has that bit at one. Writing 0, or writing only the other bit, leaves it set. A match in the same cycle as the clear keeps the flag set.
- R6: Interrupt line n is high while status bit n is set and bit 0 (alarm enable) of configuration word n is set. Configuration word 0 is at offset 0x4 and word 1 is at 0x8.
- R7: With bits 1 (periodic enable) and 2 (one-second rate) of a configuration word both set, its interrupt line pulses high for exactly one cycle after every tick. With bit 2 clear, the periodic term stays low.
- R8: A configuration word keeps and reads back only bits 2:0, with the upper bits reading zero. Writing 0 drops its interrupt line from the following cycle.
- R9: A read returns the addressed register on `rdata_o` one cycle after the request. Address bits 1:0 are ignored. Offsets 0x18 and 0x1C read as zero, and writes to them change nothing.
- R10: The two alarms are independent: a match on one alarm never sets the other alarm's status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 2 | Interrupt line per alarm |

## Verification
The hardest situations to reach from the ports are collisions in a single cycle. Two matter here: a tick arriving together with a time load, and an alarm match arriving together with a status acknowledge. Both are resolved by priority rules that ordinary sequential access never exercises. The bench drives `tick_i` and a register write on the same clock edge for each of these cases. It also lines up the count one second short of the alarm, so that the colliding tick is the matching one. The one-cycle periodic pulse is sampled in the exact cycle after a tick and again one cycle later, to confirm its width.

// File: rtl/rtcx_pkg.sv
// Package: shared constants for the seconds counter with alarms.
// Assumes word-addressed registers with byte offsets (bits 1:0 ignored).
package rtcx_pkg;
    // Width of each per-alarm configuration word
    localparam int CFG_W        = 3;
    // Bit positions within a configuration word
    localparam int CFG_ALARM_EN = 0;
    localparam int CFG_FREQ_EN  = 1;
    localparam int CFG_RATE_1HZ = 2;
    // Word indices: status first, then configuration words; time and alarms follow
    localparam int IDX_STATUS   = 0;
    localparam int IDX_CFG_BASE = 1;
endpackage

// File: rtl/rtcx_sec_counter.sv
// Module: seconds counter. Loads on a software write, otherwise steps on tick.
// Assumes tick_i is a single-cycle pulse; a load in the same cycle wins.
module rtcx_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] time_o,
    output logic [W-1:0] time_next_o,
    output logic         step_o
);
    logic [W-1:0] count_q;

    // Value the counter takes on a plain tick
    assign time_next_o = count_q + W'(1);
    // A real step only happens when no load overrides the tick
    assign step_o      = tick_i && !load_i;
    assign time_o      = count_q;

    // Counter register: reset, load or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (tick_i) begin
            count_q <= time_next_o;
        end
    end
endmodule

// File: rtl/rtcx_alarm_unit.sv
// Module: one alarm channel: target value, configuration word, sticky event flag,
// periodic pulse and interrupt line.
// Assumes step_i is high only when the counter truly advances to time_next_i.
module rtcx_alarm_unit
    import rtcx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             step_i,
    input  logic [W-1:0]     time_next_i,
    input  logic             wr_cfg_i,
    input  logic             wr_alarm_i,
    input  logic             ack_i,
    input  logic [W-1:0]     wdata_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [W-1:0]     alarm_o,
    output logic             status_o,
    output logic             irq_o
);
    logic [CFG_W-1:0] cfg_q;
    logic [W-1:0]     alarm_q;
    logic             status_q;
    logic             pulse_q;
    logic             hit;

    // Match occurs on the step that lands on the target value
    assign hit = step_i && (time_next_i == alarm_q);

    // Configuration word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg_i) begin
            cfg_q <= wdata_i[CFG_W-1:0];
        end
    end

    // Alarm target register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (wr_alarm_i) begin
            alarm_q <= wdata_i;
        end
    end

    // Sticky event flag: a new match beats an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (ack_i) begin
            status_q <= 1'b0;
        end
    end

    // One-cycle periodic pulse following each tick at the one-second rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tick_i && cfg_q[CFG_FREQ_EN] && cfg_q[CFG_RATE_1HZ];
        end
    end

    // Interrupt: latched alarm term or periodic term, each behind its enable
    assign irq_o = (status_q && cfg_q[CFG_ALARM_EN]) ||
                   (pulse_q && cfg_q[CFG_FREQ_EN]);

    assign cfg_o    = cfg_q;
    assign alarm_o  = alarm_q;
    assign status_o = status_q;
endmodule

// File: rtl/rtcx_regmap.sv
// Module: address decode into write strobes, plus the registered read mux.
// Assumes ADDR_W >= 2; the word index is addr_i[ADDR_W-1:2].
module rtcx_regmap
    import rtcx_pkg::*;
#(
    parameter int N      = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     time_i,
    input  logic [N-1:0]          status_i,
    input  logic [N*CFG_W-1:0]    cfg_flat_i,
    input  logic [N*DATA_W-1:0]   alarm_flat_i,
    output logic                  wr_status_o,
    output logic                  wr_time_o,
    output logic [N-1:0]          wr_cfg_o,
    output logic [N-1:0]          wr_alarm_o,
    output logic [DATA_W-1:0]     rdata_o
);
    localparam int IDX_W          = ADDR_W - 2;
    localparam int IDX_TIME       = IDX_CFG_BASE + N;
    localparam int IDX_ALARM_BASE = IDX_TIME + 1;

    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_low;

    assign idx        = addr_i[ADDR_W-1:2];
    assign unused_low = ^addr_i[1:0];
    assign wr_en      = req_i && we_i;
    assign rd_en      = req_i && !we_i;

    assign wr_status_o = wr_en && (idx == IDX_W'(IDX_STATUS));
    assign wr_time_o   = wr_en && (idx == IDX_W'(IDX_TIME));

    // Per-alarm write strobes, one per register
    for (genvar g = 0; g < N; g++) begin : g_strobe
        assign wr_cfg_o[g]   = wr_en && (idx == IDX_W'(IDX_CFG_BASE + g));
        assign wr_alarm_o[g] = wr_en && (idx == IDX_W'(IDX_ALARM_BASE + g));
    end

    // Read mux; unmapped indices return zero
    always_comb begin
        rd_next = '0;
        if (idx == IDX_W'(IDX_STATUS)) begin
            rd_next[N-1:0] = status_i;
        end
        if (idx == IDX_W'(IDX_TIME)) begin
            rd_next = time_i;
        end
        for (int k = 0; k < N; k++) begin
            if (idx == IDX_W'(IDX_CFG_BASE + k)) begin
                rd_next[CFG_W-1:0] = cfg_flat_i[k*CFG_W +: CFG_W];
            end
            if (idx == IDX_W'(IDX_ALARM_BASE + k)) begin
                rd_next = alarm_flat_i[k*DATA_W +: DATA_W];
            end
        end
    end

    // Read data register, updated only on a read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_next;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/rtcx_timer.sv
// Module: top of the seconds counter with alarm channels.
// Assumes NUM_ALARMS alarms laid out as status, configuration words, time, alarm values.
module rtcx_timer
    import rtcx_pkg::*;
#(
    parameter int NUM_ALARMS = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [NUM_ALARMS-1:0] irq_o
);
    logic [DATA_W-1:0]              time_q;
    logic [DATA_W-1:0]              time_next;
    logic                           step;
    logic                           wr_status;
    logic                           wr_time;
    logic [NUM_ALARMS-1:0]          wr_cfg;
    logic [NUM_ALARMS-1:0]          wr_alarm;
    logic [NUM_ALARMS-1:0]          status_q;
    logic [NUM_ALARMS*CFG_W-1:0]    cfg_flat;
    logic [NUM_ALARMS*DATA_W-1:0]   alarm_flat;

    rtcx_regmap #(.N(NUM_ALARMS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regmap (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .we_i         (we_i),
        .addr_i       (addr_i),
        .time_i       (time_q),
        .status_i     (status_q),
        .cfg_flat_i   (cfg_flat),
        .alarm_flat_i (alarm_flat),
        .wr_status_o  (wr_status),
        .wr_time_o    (wr_time),
        .wr_cfg_o     (wr_cfg),
        .wr_alarm_o   (wr_alarm),
        .rdata_o      (rdata_o)
    );

    rtcx_sec_counter #(.W(DATA_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .load_i      (wr_time),
        .load_val_i  (wdata_i),
        .time_o      (time_q),
        .time_next_o (time_next),
        .step_o      (step)
    );

    // One alarm channel per index; acknowledge bit g clears channel g
    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
        rtcx_alarm_unit #(.W(DATA_W)) u_alarm (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .step_i      (step),
            .time_next_i (time_next),
            .wr_cfg_i    (wr_cfg[g]),
            .wr_alarm_i  (wr_alarm[g]),
            .ack_i       (wr_status && wdata_i[g]),
            .wdata_i     (wdata_i),
            .cfg_o       (cfg_flat[g*CFG_W +: CFG_W]),
            .alarm_o     (alarm_flat[g*DATA_W +: DATA_W]),
            .status_o    (status_q[g]),
            .irq_o       (irq_o[g])
        );
    end
endmodule

// File: rtl/rtcx_checker.sv
// Module: protocol and behaviour checks for rtcx_timer, attached by bind.
// Assumes the default map: status 0, configuration words at 1.., time after them.
module rtcx_checker
    import rtcx_pkg::*;
#(
    parameter int N      = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_i,
    input logic                req_i,
    input logic                we_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [DATA_W-1:0]   wdata_i,
    input logic [N-1:0]        irq_o,
    input logic [DATA_W-1:0]   time_q,
    input logic [N-1:0]        status_q,
    input logic [N*CFG_W-1:0]  cfg_flat
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int IDX_TIME = IDX_CFG_BASE + N;

    logic [IDX_W-1:0] cidx;
    logic             c_wr;
    logic             c_wr_time;
    logic             c_wr_status;
    logic             unused_chk;

    assign cidx        = addr_i[ADDR_W-1:2];
    assign unused_chk  = ^addr_i[1:0];
    assign c_wr        = req_i && we_i;
    assign c_wr_time   = c_wr && (cidx == IDX_W'(IDX_TIME));
    assign c_wr_status = c_wr && (cidx == IDX_W'(IDX_STATUS));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !c_wr_time) |=> (time_q == $past(time_q) + DATA_W'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !c_wr_time) |=> $stable(time_q));

    assert_time_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_time |=> (time_q == $past(wdata_i)));

    for (genvar g = 0; g < N; g++) begin : g_chk
        logic c_wr_cfg;
        assign c_wr_cfg = c_wr && (cidx == IDX_W'(IDX_CFG_BASE + g));

        assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[g] && !(c_wr_status && wdata_i[g])) |=> status_q[g]);

        assert_status_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (c_wr_status && wdata_i[g] && !tick_i) |=> !status_q[g]);

        assert_irq_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[g] && cfg_flat[g*CFG_W + CFG_ALARM_EN]) |-> irq_o[g]);

        assert_periodic_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_i && !c_wr_cfg && cfg_flat[g*CFG_W + CFG_FREQ_EN]
             && cfg_flat[g*CFG_W + CFG_RATE_1HZ]) |=> irq_o[g]);

        assert_cfg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (c_wr_cfg && (wdata_i[CFG_W-1:0] == '0)) |=> !irq_o[g]);
    end
endmodule

bind rtcx_timer rtcx_checker #(.N(NUM_ALARMS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .time_q   (time_q),
    .status_q (status_q),
    .cfg_flat (cfg_flat)
);

// File: tb/test_rtcx_timer.sv
`timescale 1ns/1ps
module test_rtcx_timer;
    localparam int WATCHDOG = 100000;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_I = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 33;
    localparam vec_t VECS [NVEC] = '{
        '{OP_W, 4'd3,  8'h0C, 32'd100,        32'd0},
        '{OP_R, 4'd9,  8'h0C, 32'd0,          32'd100},   // R9 time readback
        '{OP_W, 4'd4,  8'h10, 32'd103,        32'd0},
        '{OP_W, 4'd6,  8'h04, 32'd1,          32'd0},
        '{OP_R, 4'd8,  8'h04, 32'd0,          32'd1},     // R8
        '{OP_T, 4'd2,  8'h00, 32'd2,          32'd0},
        '{OP_R, 4'd2,  8'h0C, 32'd0,          32'd102},   // R2
        '{OP_R, 4'd4,  8'h00, 32'd0,          32'd0},     // R4 not yet
        '{OP_I, 4'd6,  8'h00, 32'd0,          32'd0},
        '{OP_T, 4'd4,  8'h00, 32'd1,          32'd0},
        '{OP_I, 4'd6,  8'h00, 32'd0,          32'd1},     // R6
        '{OP_R, 4'd10, 8'h00, 32'd0,          32'd1},     // R10 only bit 0
        '{OP_W, 4'd5,  8'h00, 32'd0,          32'd0},
        '{OP_R, 4'd5,  8'h00, 32'd0,          32'd1},     // R5 zero write
        '{OP_W, 4'd5,  8'h00, 32'd2,          32'd0},
        '{OP_R, 4'd5,  8'h00, 32'd0,          32'd1},     // R5 other bit
        '{OP_W, 4'd5,  8'h00, 32'd1,          32'd0},
        '{OP_R, 4'd5,  8'h00, 32'd0,          32'd0},     // R5 acknowledged
        '{OP_I, 4'd6,  8'h00, 32'd0,          32'd0},
        '{OP_W, 4'd4,  8'h14, 32'd105,        32'd0},
        '{OP_T, 4'd4,  8'h00, 32'd2,          32'd0},
        '{OP_R, 4'd10, 8'h00, 32'd0,          32'd2},     // R10 / R5 sticky
        '{OP_I, 4'd6,  8'h00, 32'd0,          32'd0},
        '{OP_W, 4'd6,  8'h08, 32'd1,          32'd0},
        '{OP_I, 4'd6,  8'h00, 32'd0,          32'd2},     // R6 alarm 1
        '{OP_W, 4'd8,  8'h08, 32'd0,          32'd0},
        '{OP_I, 4'd8,  8'h00, 32'd0,          32'd0},     // R8 disable
        '{OP_W, 4'd8,  8'h04, 32'hFFFF_FFFF,  32'd0},
        '{OP_R, 4'd8,  8'h04, 32'd0,          32'd7},     // R8 width
        '{OP_W, 4'd8,  8'h04, 32'd0,          32'd0},
        '{OP_W, 4'd5,  8'h00, 32'd3,          32'd0},
        '{OP_R, 4'd5,  8'h00, 32'd0,          32'd0},
        '{OP_R, 4'd9,  8'h14, 32'd0,          32'd105}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtcx_timer i_rtcx_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .req_i   (req_i),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        @(negedge clk);
        req_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        do_reset();
        // R1 reset state
        check("R1 rdata", rdata_o, 32'd0);
        check("R1 irq", {30'd0, irq_o}, 32'd0);
        bus_read(5'h0C, rd); check("R1 time", rd, 32'd0);
        bus_read(5'h04, rd); check("R1 cfg0", rd, 32'd0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VECS[i].op)
                OP_W: bus_write(VECS[i].addr[4:0], VECS[i].data);
                OP_R: begin
                    bus_read(VECS[i].addr[4:0], rd);
                    check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].exp);
                end
                OP_T: for (int k = 0; k < int'(VECS[i].data); k++) tick_once();
                default: check($sformatf("R%0d vec %0d irq", VECS[i].req, i),
                               {30'd0, irq_o}, VECS[i].exp);
            endcase
        end

        // R2 wrap-around
        bus_write(5'h0C, 32'hFFFF_FFFF);
        tick_once();
        bus_read(5'h0C, rd); check("R2 wrap", rd, 32'd0);

        // R3 load collides with tick: load wins, then counting resumes
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = 5'h0C; wdata_i = 32'd500; tick_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
        bus_read(5'h0C, rd); check("R3 load over tick", rd, 32'd500);
        tick_once();
        bus_read(5'h0C, rd); check("R3 resume", rd, 32'd501);

        // R4 loading the time onto the alarm value sets no flag
        bus_write(5'h10, 32'd600);
        bus_write(5'h0C, 32'd600);
        bus_read(5'h00, rd); check("R4 load no match", rd, 32'd0);
        tick_once();
        bus_read(5'h00, rd); check("R4 past target", rd, 32'd0);

        // R5 match and acknowledge in the same cycle: flag stays set
        bus_write(5'h10, 32'd602);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = 5'h00; wdata_i = 32'd1; tick_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
        bus_read(5'h00, rd); check("R5 set beats clear", rd, 32'd1);
        bus_write(5'h00, 32'd1);
        bus_read(5'h00, rd); check("R5 clear after", rd, 32'd0);

        // R7 periodic pulse width and rate select
        bus_write(5'h04, 32'd6);
        check("R7 idle", {30'd0, irq_o}, 32'd0);
        tick_once();
        check("R7 pulse", {30'd0, irq_o}, 32'd1);
        @(negedge clk);
        check("R7 one cycle", {30'd0, irq_o}, 32'd0);
        bus_write(5'h04, 32'd2);
        tick_once();
        check("R7 no rate", {30'd0, irq_o}, 32'd0);
        bus_write(5'h04, 32'd0);

        // R9 unmapped offsets and ignored low address bits
        bus_write(5'h18, 32'hDEAD_BEEF);
        bus_read(5'h18, rd); check("R9 unmapped 0x18", rd, 32'd0);
        bus_read(5'h1C, rd); check("R9 unmapped 0x1C", rd, 32'd0);
        bus_read(5'h0E, rd); check("R9 low bits", rd, 32'd604);

        // R1 reset in mid-run clears everything
        bus_write(5'h04, 32'd7);
        bus_write(5'h10, 32'd700);
        do_reset();
        check("R1 irq after", {30'd0, irq_o}, 32'd0);
        bus_read(5'h0C, rd); check("R1 time after", rd, 32'd0);
        bus_read(5'h04, rd); check("R1 cfg0 after", rd, 32'd0);
        bus_read(5'h10, rd); check("R1 alarm0 after", rd, 32'd0);
        bus_read(5'h14, rd); check("R1 alarm1 after", rd, 32'd0);
        bus_read(5'h00, rd); check("R1 status after", rd, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule